// File: doc/BRIEF.md
# Serial Flash Slave Front-End

This block is the serial front end of a flash memory device that answers to an SPI master. It samples chip select, serial clock, serial data in, a pause (hold) input and a write-protect input with the device's own system clock. It turns the incoming bit stream into bytes and hands each byte to the internal control logic. Each byte carries a flag that marks the first byte of a frame as the opcode, and its position within the frame. One-cycle strobes mark the start and the end of every frame.

For read-type commands, the control logic places a byte on `tx_byte`. The block shifts that byte out most significant bit first on the falling edges of the serial clock. An output-enable drives the pad's tri-state buffer. The pause input freezes all shifting and releases the output pad. The pause begins only while the serial clock is low. A busy input stands in for the self-timed program and erase engine. The block reports standby only when the device is deselected and no internal operation is running.

Top module: `spi_flash_front`

## Requirements
- R1: Bits on `si` are captured on rising `sck` edges, MSB first. After every eighth captured bit of a frame, `rx_valid` pulses for exactly one cycle and `rx_byte` holds the assembled byte.
- R2: With each `rx_valid`, `rx_is_op` is 1 for the first byte of a frame and 0 otherwise. `rx_index` gives the byte's position in the frame, starting at 0 and saturating at its maximum.
- R3: A falling `cs_n` produces a one-cycle `sof` pulse. A rising `cs_n` produces a one-cycle `eof` pulse. The two never occur together.
- R4: Each new frame clears the bit count and the byte position, so bits left over from an aborted frame never reach a byte.
- R5: While `cs_n` is high, `sck` and `si` are ignored: no byte is reported and `so_oe` stays 0.
- R6: `so_o` changes only on falling `sck` edges. The first falling edge of each byte loads `tx_byte`, and later falling edges shift it MSB first. Both clock idle levels work: low (mode 0) and high (mode 3).
- R7: A low `hold_n` during a frame pauses the interface. Clock edges and data are ignored and `so_oe` is 0 until `hold_n` returns high. The pause starts only once `sck` is low, and is deferred while `sck` is high.
- R8: `standby` is 1 only when the device is deselected and `busy_in` is 0. A rising `cs_n` during a busy operation keeps `standby` at 0 until `busy_in` clears. Neither pausing nor deselect affects `busy_in`.
- R9: `wp_lock` is the active-high form of the active-low `wp_n` input, synchronised to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low, idles high |
| wp_n | input | 1 | Write protect, active low, idles high |
| busy_in | input | 1 | Internal program/erase operation running |
| tx_byte | input | DATA_W | Byte to send on the serial output |
| so_o | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the serial output pad |
| rx_byte | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: new byte on rx_byte |
| rx_is_op | output | 1 | Byte is the first (opcode) byte of the frame |
| rx_index | output | IDX_W | Byte position within the frame |
| sof | output | 1 | Start-of-frame strobe |
| eof | output | 1 | End-of-frame strobe |
| standby | output | 1 | Deselected and no internal operation busy |
| wp_lock | output | 1 | Hardware write protection asserted |

## Verification
Every pin passes through two synchroniser flops and then one result register. A change on a pin therefore shows on `rx_valid`, `sof`, `eof`, `standby`, `wp_lock` and `so_oe` after the third rising `clk` edge, and a falling `sck` moves `so_o` after the same delay. The bench keeps a record of every pin value it applied. Its behavioural model reads the entries two and three clocks old and compares every output on every falling `clk` edge. Each serial clock phase lasts eight system clocks, so the master-side reads of `so_o` happen well after the output has settled.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  localparam int unsigned PIN_W = 5;

  typedef struct packed {
    logic cs_n;
    logic sck;
    logic si;
    logic hold_n;
    logic wp_n;
  } pins_t;

  // Pin levels of an idle, deselected bus (pull-ups on hold and write protect)
  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, si: 1'b0, hold_n: 1'b1, wp_n: 1'b1};

endpackage

// File: rtl/spi_fe_rstsync.sv
module spi_fe_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sn = chain_q[STAGES-1];

endmodule

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] st_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= {st_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = st_q[STAGES-1];

endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sck_lvl,
  input  logic hold_n_lvl,
  output logic hold_act
);

  logic hold_d;

  // Entry needs a selected device and a low clock; release on hold_n high or deselect
  always_comb begin
    hold_d = sel & ~hold_n_lvl & (hold_act | ~sck_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_act <= 1'b0;
    else        hold_act <= hold_d;
  end

endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              rise,
  input  logic              fall,
  input  logic              si_lvl,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              so_bit,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_is_op,
  output logic [IDX_W-1:0]  rx_index
);

  localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] IDX_MAX  = '1;

  logic [CNT_W-1:0]  bit_q,  bit_d;
  logic [IDX_W-1:0]  idx_q,  idx_d;
  logic [DATA_W-2:0] acc_q,  acc_d;
  logic [DATA_W-1:0] tx_q,   tx_d;
  logic              vld_q,  vld_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              op_q,   op_d;
  logic [IDX_W-1:0]  pos_q,  pos_d;

  always_comb begin
    bit_d  = bit_q;
    idx_d  = idx_q;
    acc_d  = acc_q;
    tx_d   = tx_q;
    vld_d  = 1'b0;
    byte_d = byte_q;
    op_d   = op_q;
    pos_d  = pos_q;
    if (frame_start) begin
      bit_d = '0;
      idx_d = '0;
    end else begin
      if (rise) begin
        acc_d = {acc_q[DATA_W-3:0], si_lvl};
        if (bit_q == LAST_BIT) begin
          bit_d  = '0;
          vld_d  = 1'b1;
          byte_d = {acc_q, si_lvl};
          op_d   = (idx_q == '0);
          pos_d  = idx_q;
          if (idx_q != IDX_MAX) idx_d = idx_q + 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
      if (fall) begin
        if (bit_q == '0) tx_d = tx_byte;
        else             tx_d = {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      idx_q  <= '0;
      acc_q  <= '0;
      tx_q   <= '0;
      vld_q  <= 1'b0;
      byte_q <= '0;
      op_q   <= 1'b0;
      pos_q  <= '0;
    end else begin
      bit_q  <= bit_d;
      idx_q  <= idx_d;
      acc_q  <= acc_d;
      tx_q   <= tx_d;
      vld_q  <= vld_d;
      byte_q <= byte_d;
      op_q   <= op_d;
      pos_q  <= pos_d;
    end
  end

  assign so_bit   = tx_q[DATA_W-1];
  assign rx_valid = vld_q;
  assign rx_byte  = byte_q;
  assign rx_is_op = op_q;
  assign rx_index = pos_q;

endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  input  logic              wp_n,
  input  logic              busy_in,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              so_o,
  output logic              so_oe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              rx_is_op,
  output logic [IDX_W-1:0]  rx_index,
  output logic              sof,
  output logic              eof,
  output logic              standby,
  output logic              wp_lock
);
  import spi_fe_pkg::*;

  logic  rst_sn;
  pins_t pin_raw, pin_s;
  logic  sel, hold_act, rise, fall, so_bit;
  logic  cs_dq, sck_dq, sof_q, eof_q, stby_q, wp_q;
  logic  sof_d, eof_d, stby_d, wp_d;

  spi_fe_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_sn(rst_sn)
  );

  assign pin_raw = '{cs_n: cs_n, sck: sck, si: si, hold_n: hold_n, wp_n: wp_n};

  spi_fe_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d(pin_raw), .q(pin_s)
  );

  assign sel = ~pin_s.cs_n;

  spi_fe_hold u_hold (
    .clk(clk), .rst_n(rst_sn), .sel(sel), .sck_lvl(pin_s.sck),
    .hold_n_lvl(pin_s.hold_n), .hold_act(hold_act)
  );

  always_comb begin
    rise   = sel & ~hold_act &  pin_s.sck & ~sck_dq;
    fall   = sel & ~hold_act & ~pin_s.sck &  sck_dq;
    sof_d  = sel & cs_dq;
    eof_d  = ~sel & ~cs_dq;
    stby_d = ~sel & ~busy_in;
    wp_d   = ~pin_s.wp_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_dq  <= 1'b1;
      sck_dq <= 1'b0;
      sof_q  <= 1'b0;
      eof_q  <= 1'b0;
      stby_q <= 1'b1;
      wp_q   <= 1'b0;
    end else if (!rst_sn) begin
      cs_dq  <= 1'b1;
      sck_dq <= 1'b0;
      sof_q  <= 1'b0;
      eof_q  <= 1'b0;
      stby_q <= 1'b1;
      wp_q   <= 1'b0;
    end else begin
      cs_dq  <= pin_s.cs_n;
      sck_dq <= pin_s.sck;
      sof_q  <= sof_d;
      eof_q  <= eof_d;
      stby_q <= stby_d;
      wp_q   <= wp_d;
    end
  end

  spi_fe_shift #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shift (
    .clk(clk), .rst_n(rst_sn), .frame_start(sof_d), .rise(rise), .fall(fall),
    .si_lvl(pin_s.si), .tx_byte(tx_byte), .so_bit(so_bit),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_is_op(rx_is_op), .rx_index(rx_index)
  );

  assign so_oe   = ~cs_dq & ~hold_act;
  assign so_o    = so_oe & so_bit;
  assign sof     = sof_q;
  assign eof     = eof_q;
  assign standby = stby_q;
  assign wp_lock = wp_q;

endmodule

// File: rtl/spi_fe_chk.sv
module spi_fe_chk #(
  parameter int unsigned IDX_W = 4
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             rx_valid,
  input logic             rx_is_op,
  input logic [IDX_W-1:0] rx_index,
  input logic             sof,
  input logic             eof,
  input logic             so_oe,
  input logic             hold_act,
  input logic             busy_in,
  input logic             standby
);

  p_vld_pulse_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    rx_valid |=> !rx_valid);

  p_op_first_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (rx_valid && rx_is_op) |-> (rx_index == '0));

  p_frame_excl_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    !(sof && eof));

  p_end_quiet_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    eof |-> !so_oe);

  p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    hold_act |=> !rx_valid);

  p_busy_standby_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    busy_in |=> !standby);

endmodule

bind spi_flash_front spi_fe_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .rx_valid(rx_valid), .rx_is_op(rx_is_op),
  .rx_index(rx_index), .sof(sof), .eof(eof), .so_oe(so_oe),
  .hold_act(hold_act), .busy_in(busy_in), .standby(standby)
);

// File: tb/sim_spi_flash_front.sv
module sim_spi_flash_front;

  localparam int HALF = 8;

  logic       clk, rst_n, cs_n, sck, si, hold_n, wp_n, busy_in;
  logic [7:0] tx_byte, rx_byte;
  logic       so_o, so_oe, rx_valid, rx_is_op, sof, eof, standby, wp_lock;
  logic [3:0] rx_index;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, done = 0;
  int n_sof = 0, n_eof = 0;
  int q_byte[$], q_op[$], q_idx[$];

  spi_flash_front u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .busy_in(busy_in), .tx_byte(tx_byte), .so_o(so_o), .so_oe(so_oe),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_is_op(rx_is_op), .rx_index(rx_index),
    .sof(sof), .eof(eof), .standby(standby), .wp_lock(wp_lock)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- behavioural reference model ----------------
  // pin record: [4]=cs_n [3]=sck [2]=si [1]=hold_n [0]=wp_n ; newest at front
  logic [4:0] hist[$];
  bit m_hold, m_vld, m_op, m_sof, m_eof, m_stby, m_wp;
  int m_bits, m_idx, m_sh, m_tx, m_byte, m_ridx;

  initial begin
    for (int k = 0; k < 4; k++) hist.push_front(5'b10011);
    m_hold = 0; m_vld = 0; m_op = 0; m_sof = 0; m_eof = 0; m_stby = 1; m_wp = 0;
    m_bits = 0; m_idx = 0; m_sh = 0; m_tx = 0; m_byte = 0; m_ridx = 0;
  end

  always @(posedge clk) begin
    logic [4:0] cur, prv;
    bit selc, selp, r, f;
    hist.push_front({cs_n, sck, si, hold_n, wp_n});
    if (hist.size() > 6) void'(hist.pop_back());
    cur = hist[2];
    prv = hist[3];
    if (!rst_n) begin
      m_hold = 0; m_vld = 0; m_sof = 0; m_eof = 0; m_stby = 1; m_wp = 0;
      m_bits = 0; m_idx = 0; m_tx = 0;
    end else begin
      selc = !cur[4];
      selp = !prv[4];
      r = selc && !m_hold && cur[3] && !prv[3];
      f = selc && !m_hold && !cur[3] && prv[3];
      m_vld = 0;
      if (selc && !selp) begin
        m_bits = 0;
        m_idx  = 0;
      end else begin
        if (r) begin
          m_sh = ((m_sh << 1) | int'(cur[2])) & 255;
          m_bits++;
          if (m_bits == 8) begin
            m_bits = 0;
            m_vld  = 1;
            m_byte = m_sh;
            m_op   = (m_idx == 0);
            m_ridx = m_idx;
            if (m_idx < 15) m_idx++;
          end
        end
        if (f) m_tx = (m_bits == 0) ? int'(tx_byte) : ((m_tx << 1) & 255);
      end
      m_hold = selc && !cur[1] && (m_hold || !cur[3]);
      m_sof  = selc && !selp;
      m_eof  = !selc && selp;
      m_stby = !selc && !busy_in;
      m_wp   = !cur[0];
    end
  end

  // compare every cycle, away from the active edge; collect received bytes
  always @(negedge clk) begin
    bit e_oe;
    if (rx_valid) begin
      q_byte.push_back(int'(rx_byte));
      q_op.push_back(int'(rx_is_op));
      q_idx.push_back(int'(rx_index));
    end
    if (sof) n_sof++;
    if (eof) n_eof++;
    if (cmp_on) begin
      e_oe = !hist[2][4] && !m_hold;
      chk(rx_valid == m_vld, "R1 rx_valid vs model", rx_valid, m_vld);
      if (m_vld) begin
        chk(rx_byte == m_byte[7:0], "R1 rx_byte vs model", rx_byte, m_byte);
        chk(rx_is_op == m_op, "R2 rx_is_op vs model", rx_is_op, m_op);
        chk(rx_index == m_ridx[3:0], "R2 rx_index vs model", rx_index, m_ridx);
      end
      chk(sof == m_sof, "R3 sof vs model", sof, m_sof);
      chk(eof == m_eof, "R3 eof vs model", eof, m_eof);
      chk(so_oe == e_oe, "R5 R7 so_oe vs model", so_oe, e_oe);
      if (e_oe) chk(so_o == m_tx[7], "R6 so_o vs model", so_o, m_tx[7]);
      chk(standby == m_stby, "R8 standby vs model", standby, m_stby);
      chk(wp_lock == m_wp, "R9 wp_lock vs model", wp_lock, m_wp);
    end
  end

  // ---------------- master-side tasks ----------------
  task automatic bitx(input logic b);
    sck = 1'b0; si = b; tick(HALF);
    sck = 1'b1; tick(HALF);
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = b[i]; tick(HALF);
      got[i] = so_o;
      sck = 1'b1; tick(HALF);
    end
  endtask

  task automatic sel_on(input bit mode3);
    sck = mode3; tick(HALF);
    cs_n = 1'b0; tick(HALF);
  endtask

  task automatic sel_off(input bit mode3);
    sck = mode3; tick(HALF);
    cs_n = 1'b1; tick(2 * HALF);
  endtask

  task automatic expect_rx(input int k, input int b, input int op, input int idx, input string tg);
    if (q_byte.size() <= k) begin
      chk(0, {tg, " byte missing"}, q_byte.size(), k + 1);
    end else begin
      chk(q_byte[k] == b, {tg, " byte"}, q_byte[k], b);
      chk(q_op[k] == op, {tg, " opcode flag"}, q_op[k], op);
      chk(q_idx[k] == idx, {tg, " index"}, q_idx[k], idx);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    int s0, e0;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1; wp_n = 1'b1;
    busy_in = 1'b0; tx_byte = 8'h00;
    tick(4);
    chk(so_oe == 1'b0, "R5 reset so_oe", so_oe, 0);
    chk(rx_valid == 1'b0, "R1 reset rx_valid", rx_valid, 0);
    chk(standby == 1'b1, "R8 reset standby", standby, 1);
    chk(sof == 1'b0 && eof == 1'b0, "R3 reset strobes", {sof, eof}, 0);
    rst_n = 1'b1;
    tick(6);
    cmp_on = 1;

    // mode 0 frame: opcode + three bytes, readback on bytes 1..3
    tx_byte = 8'hC3;
    q_byte.delete(); q_op.delete(); q_idx.delete();
    s0 = n_sof; e0 = n_eof;
    sel_on(0);
    chk(standby == 1'b0, "R8 standby while selected", standby, 0);
    xfer(8'h9F, g);
    xfer(8'h12, g); chk(g == 8'hC3, "R6 mode0 readback 1", g, 8'hC3);
    xfer(8'h34, g); chk(g == 8'hC3, "R6 mode0 readback 2", g, 8'hC3);
    xfer(8'h56, g); chk(g == 8'hC3, "R6 mode0 readback 3", g, 8'hC3);
    sel_off(0);
    expect_rx(0, 8'h9F, 1, 0, "R1 R2 mode0 b0");
    expect_rx(1, 8'h12, 0, 1, "R1 R2 mode0 b1");
    expect_rx(3, 8'h56, 0, 3, "R1 R2 mode0 b3");
    chk(n_sof - s0 == 1, "R3 one sof per frame", n_sof - s0, 1);
    chk(n_eof - e0 == 1, "R3 one eof per frame", n_eof - e0, 1);

    // mode 3 frame: clock idles high
    tx_byte = 8'h5A;
    q_byte.delete(); q_op.delete(); q_idx.delete();
    sel_on(1);
    xfer(8'h0B, g); chk(g == 8'h5A, "R6 mode3 readback 0", g, 8'h5A);
    xfer(8'hA5, g); chk(g == 8'h5A, "R6 mode3 readback 1", g, 8'h5A);
    sel_off(1);
    expect_rx(0, 8'h0B, 1, 0, "R1 R2 mode3 b0");
    expect_rx(1, 8'hA5, 0, 1, "R1 R2 mode3 b1");

    // aborted frame: partial byte must be discarded
    q_byte.delete(); q_op.delete(); q_idx.delete();
    sel_on(0);
    bitx(1); bitx(1); bitx(0);
    sel_off(0);
    chk(q_byte.size() == 0, "R4 no byte from partial frame", q_byte.size(), 0);
    sel_on(0);
    xfer(8'h81, g);
    sel_off(0);
    chk(q_byte.size() == 1, "R4 byte count after abort", q_byte.size(), 1);
    expect_rx(0, 8'h81, 1, 0, "R4 fresh frame");

    // deselected clocking is ignored
    q_byte.delete(); q_op.delete(); q_idx.delete();
    for (int i = 0; i < 10; i++) begin
      bitx(i[0]);
      chk(so_oe == 1'b0, "R5 so_oe off when deselected", so_oe, 0);
    end
    sck = 1'b0; tick(HALF);
    chk(q_byte.size() == 0, "R5 no byte when deselected", q_byte.size(), 0);

    // hold: deferred entry while sck high, freeze, resume
    tx_byte = 8'h3C;
    sel_on(0);
    bitx(1); bitx(1); bitx(0); bitx(0);
    hold_n = 1'b0; tick(HALF);
    chk(so_oe == 1'b1, "R7 hold deferred while sck high", so_oe, 1);
    sck = 1'b0; tick(HALF);
    chk(so_oe == 1'b0, "R7 hold entered with sck low", so_oe, 0);
    busy_in = 1'b1;
    for (int i = 0; i < 6; i++) bitx(1'b1);
    sck = 1'b0; tick(HALF);
    chk(q_byte.size() == 0, "R7 no byte during hold", q_byte.size(), 0);
    chk(so_oe == 1'b0, "R7 so_oe off during hold", so_oe, 0);
    hold_n = 1'b1; tick(HALF);
    chk(so_oe == 1'b1, "R7 so_oe back after hold", so_oe, 1);
    bitx(0); bitx(1); bitx(1); bitx(0);
    sel_off(0);
    expect_rx(0, 8'hC6, 1, 0, "R7 byte across hold");

    // busy keeps standby low after deselect
    chk(standby == 1'b0, "R8 standby low while busy", standby, 0);
    tick(20);
    chk(standby == 1'b0, "R8 standby still low while busy", standby, 0);
    busy_in = 1'b0; tick(4);
    chk(standby == 1'b1, "R8 standby after busy clears", standby, 1);

    // write protect
    wp_n = 1'b0; tick(4);
    chk(wp_lock == 1'b1, "R9 wp_lock set", wp_lock, 1);
    wp_n = 1'b1; tick(4);
    chk(wp_lock == 1'b0, "R9 wp_lock clear", wp_lock, 0);

    tick(10);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule